// File: doc/BRIEF.md
# Interleaved Address Translator

This block converts a linear byte offset inside a device window into the physical byte offset where that byte sits inside an interleaved system address range. The window is cut into lines of a configured size. Consecutive lines are spread over the range through a small table of per-line positions. Once every table entry has been used, the whole pattern repeats one table stride further on. That stride spans the table's lines times the number of interleave ways times the line size.

Callers present one offset per cycle on a valid/ready request port. Each result appears two cycles later on the response port. The response carries the translated offset, the number of bytes left before the current line ends, and an overflow flag. The remaining-bytes count lets software or a DMA engine split an access so that it never crosses a line. Configuration is static while requests are in flight. When the table length is zero, interleaving is switched off and offsets pass through untouched.

Top module: `ilv_xlate`

## Requirements
- R1: `req_ready` is low, and requests presented are ignored (no response follows), when `cfg_num_lines` is nonzero and `cfg_ways` is zero, or when `cfg_num_lines` is not one of 0, 1, 2, 4, 8, 16.
- R2: With `cfg_num_lines` = 0, `rsp_off` equals the request offset, `rsp_left` is 0 and `rsp_err` is 0; `cfg_ways` = 0 is accepted in this mode.
- R3: With interleaving on, let L = 2^`cfg_line_lg2` and N = `cfg_num_lines`. Then `rsp_off` = base + T[(off/L) mod N]·L + ((off/L) div N)·N·ways·L + (off mod L), taken modulo 2^64. Table entry T[i] occupies bits [32i+31:32i] of `cfg_table`.
- R4: With interleaving on, `rsp_left` = L − (off mod L), a value from 1 to L.
- R5: `rsp_err` is 1 exactly when the exact sum in R3 is 2^64 or more.
- R6: A request accepted at clock edge k produces `rsp_valid` at edge k+2 and at no other edge. Back-to-back requests are accepted every cycle, and responses come out in order.
- R7: While `rst_n` is low (synchronous), `rsp_valid` is 0 after each clock edge.
- R8: `cfg_line_lg2` covers line sizes from 1 byte (0) up to 32768 bytes (15).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_line_lg2 | input | 4 | log2 of the line size in bytes |
| cfg_num_lines | input | 5 | Table length (0 disables interleaving) |
| cfg_ways | input | 16 | Interleave ways |
| cfg_base | input | 64 | Base offset added to every translated result |
| cfg_table | input | 512 | Sixteen 32-bit line positions, entry i at bits [32i+31:32i] |
| req_valid | input | 1 | Request offset is valid |
| req_ready | output | 1 | Configuration is usable and requests are accepted |
| req_off | input | 64 | Linear offset in the device window |
| rsp_valid | output | 1 | Response is valid |
| rsp_off | output | 64 | Translated offset |
| rsp_left | output | 17 | Bytes left in the current line |
| rsp_err | output | 1 | Translation overflowed 64 bits |

## Verification
The hardest case to reach from the ports is the repeat stride. It only shows up when the line number runs past the table length, so that a nonzero skip count multiplies the stride. The hard part is doing that while the table entry, sub-line remainder and base offset all stay distinguishable in the result. The stimulus uses tables whose entries are a scrambled permutation and several line sizes. Offsets are chosen to land several table lengths deep, at line ends and at line starts. A base near 2^64 pushes the sum past the top to exercise the overflow flag. Invalid table lengths and zero ways are applied while requests are held valid, to show they are dropped.

// File: rtl/ilv_pkg.sv
// Package: default widths shared by the interleave translator modules.
// Assumes: line size and table length are powers of two.
package ilv_pkg;
    localparam int OFF_W  = 64;  // byte offset width
    localparam int ENT_W  = 32;  // table entry width
    localparam int TBL_N  = 16;  // maximum table length
    localparam int WAYS_W = 16;  // interleave ways width
    localparam int LG_W   = 4;   // line size exponent width
endpackage

// File: rtl/ilv_cfg_check.sv
// Module: validates the configuration and derives log2 of the table length.
// Assumes: configuration is static while requests are in flight.
module ilv_cfg_check #(
    parameter int TBL_N  = ilv_pkg::TBL_N,
    parameter int WAYS_W = ilv_pkg::WAYS_W,
    localparam int CNT_W = $clog2(TBL_N + 1),
    localparam int IDX_W = $clog2(TBL_N),
    localparam int LLG_W = $clog2(IDX_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  num_lines,
    input  logic [WAYS_W-1:0] ways,
    output logic [LLG_W-1:0]  lines_lg2,
    output logic              ilv_on,
    output logic              cfg_ok
);
    logic [IDX_W:0] hit;

    // One match flag per legal power-of-two table length.
    for (genvar i = 0; i <= IDX_W; i++) begin : g_pow
        assign hit[i] = (num_lines == CNT_W'(1 << i));
    end

    // Encode the matching exponent.
    always_comb begin
        lines_lg2 = '0;
        for (int i = 0; i <= IDX_W; i++) begin
            if (hit[i]) lines_lg2 = LLG_W'(i);
        end
    end

    // Usable when disabled, or a power of two with at least one way.
    always_comb begin
        ilv_on = (num_lines != '0);
        cfg_ok = !ilv_on || ((|hit) && (ways != '0));
    end

    p_zero_ways_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (num_lines != '0 && ways == '0) |-> !cfg_ok);
endmodule

// File: rtl/ilv_split.sv
// Module: stage one; splits the offset into line index, skip count and
// sub-line remainder using shifts and masks.
// Assumes: line size 2^line_lg2, table length 2^lines_lg2.
module ilv_split #(
    parameter int OFF_W = ilv_pkg::OFF_W,
    parameter int TBL_N = ilv_pkg::TBL_N,
    parameter int LG_W  = ilv_pkg::LG_W,
    localparam int IDX_W  = $clog2(TBL_N),
    localparam int LLG_W  = $clog2(IDX_W + 1),
    localparam int LEFT_W = (1 << LG_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OFF_W-1:0]  in_off,
    input  logic [LG_W-1:0]   line_lg2,
    input  logic [LLG_W-1:0]  lines_lg2,
    input  logic              ilv_on,
    output logic              s1_valid,
    output logic              s1_pass,
    output logic [OFF_W-1:0]  s1_raw,
    output logic [IDX_W-1:0]  s1_idx,
    output logic [OFF_W-1:0]  s1_skip,
    output logic [LEFT_W-1:0] s1_sub
);
    logic [OFF_W-1:0] line_no;
    logic [OFF_W-1:0] sub_mask;
    logic [IDX_W-1:0] idx_mask;

    // Line number, remainder mask and index mask from the exponents.
    always_comb begin
        line_no  = in_off >> line_lg2;
        sub_mask = (OFF_W'(1) << line_lg2) - OFF_W'(1);
        idx_mask = IDX_W'((TBL_N'(1) << lines_lg2) - 1);
    end

    // Stage-one pipeline register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
        end else begin
            s1_valid <= in_valid;
        end
        s1_pass <= !ilv_on;
        s1_raw  <= in_off;
        s1_idx  <= line_no[IDX_W-1:0] & idx_mask;
        s1_skip <= line_no >> lines_lg2;
        s1_sub  <= LEFT_W'(in_off & sub_mask);
    end

    p_sub_in_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> (s1_sub < (LEFT_W'(1) << line_lg2)));
endmodule

// File: rtl/ilv_place.sv
// Module: stage two; looks up the line position, adds the table stride
// term, base and remainder, and flags a sum that exceeds the offset width.
// Assumes: skip < 2^(OFF_W - line_lg2 - lines_lg2), so WIDE_W cannot wrap.
module ilv_place #(
    parameter int OFF_W  = ilv_pkg::OFF_W,
    parameter int ENT_W  = ilv_pkg::ENT_W,
    parameter int TBL_N  = ilv_pkg::TBL_N,
    parameter int WAYS_W = ilv_pkg::WAYS_W,
    parameter int LG_W   = ilv_pkg::LG_W,
    localparam int IDX_W  = $clog2(TBL_N),
    localparam int LLG_W  = $clog2(IDX_W + 1),
    localparam int LEFT_W = (1 << LG_W) + 1,
    localparam int WIDE_W = OFF_W + WAYS_W + 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   s1_valid,
    input  logic                   s1_pass,
    input  logic [OFF_W-1:0]       s1_raw,
    input  logic [IDX_W-1:0]       s1_idx,
    input  logic [OFF_W-1:0]       s1_skip,
    input  logic [LEFT_W-1:0]      s1_sub,
    input  logic [LG_W-1:0]        line_lg2,
    input  logic [LLG_W-1:0]       lines_lg2,
    input  logic [WAYS_W-1:0]      ways,
    input  logic [OFF_W-1:0]       base,
    input  logic [TBL_N*ENT_W-1:0] table_flat,
    output logic                   rsp_valid,
    output logic [OFF_W-1:0]       rsp_off,
    output logic [LEFT_W-1:0]      rsp_left,
    output logic                   rsp_err
);
    logic [ENT_W-1:0]  entry;
    logic [WIDE_W-1:0] line_term;
    logic [WIDE_W-1:0] table_term;
    logic [WIDE_W-1:0] total;
    logic              rsp_pass;

    // Sum of base, line position, table stride term and remainder.
    always_comb begin
        entry      = table_flat[s1_idx*ENT_W +: ENT_W];
        line_term  = WIDE_W'(entry) << line_lg2;
        table_term = (WIDE_W'(s1_skip) * WIDE_W'(ways))
                     << (WIDE_W'(line_lg2) + WIDE_W'(lines_lg2));
        total      = WIDE_W'(base) + line_term + table_term + WIDE_W'(s1_sub);
    end

    // Stage-two (output) register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= s1_valid;
        end
        rsp_pass <= s1_pass;
        if (s1_pass) begin
            rsp_off  <= s1_raw;
            rsp_left <= '0;
            rsp_err  <= 1'b0;
        end else begin
            rsp_off  <= total[OFF_W-1:0];
            rsp_left <= (LEFT_W'(1) << line_lg2) - s1_sub;
            rsp_err  <= |total[WIDE_W-1:OFF_W];
        end
    end

    p_left_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_pass) |->
            (rsp_left != '0 && rsp_left <= (LEFT_W'(1) << line_lg2)));
    p_pass_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_pass) |-> (!rsp_err && rsp_left == '0));
endmodule

// File: rtl/ilv_xlate.sv
// Module: top of the interleaved address translator. Two-stage pipeline,
// one request per cycle, fixed latency of two clocks, no response stall.
// Assumes: configuration inputs change only while the pipeline is empty.
module ilv_xlate #(
    parameter int OFF_W  = ilv_pkg::OFF_W,
    parameter int ENT_W  = ilv_pkg::ENT_W,
    parameter int TBL_N  = ilv_pkg::TBL_N,
    parameter int WAYS_W = ilv_pkg::WAYS_W,
    parameter int LG_W   = ilv_pkg::LG_W,
    localparam int CNT_W  = $clog2(TBL_N + 1),
    localparam int IDX_W  = $clog2(TBL_N),
    localparam int LLG_W  = $clog2(IDX_W + 1),
    localparam int LEFT_W = (1 << LG_W) + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LG_W-1:0]        cfg_line_lg2,
    input  logic [CNT_W-1:0]       cfg_num_lines,
    input  logic [WAYS_W-1:0]      cfg_ways,
    input  logic [OFF_W-1:0]       cfg_base,
    input  logic [TBL_N*ENT_W-1:0] cfg_table,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [OFF_W-1:0]       req_off,
    output logic                   rsp_valid,
    output logic [OFF_W-1:0]       rsp_off,
    output logic [LEFT_W-1:0]      rsp_left,
    output logic                   rsp_err
);
    logic [LLG_W-1:0]  lines_lg2;
    logic              ilv_on;
    logic              cfg_ok;
    logic              s1_valid;
    logic              s1_pass;
    logic [OFF_W-1:0]  s1_raw;
    logic [IDX_W-1:0]  s1_idx;
    logic [OFF_W-1:0]  s1_skip;
    logic [LEFT_W-1:0] s1_sub;

    ilv_cfg_check #(.TBL_N(TBL_N), .WAYS_W(WAYS_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .num_lines(cfg_num_lines), .ways(cfg_ways),
        .lines_lg2(lines_lg2), .ilv_on(ilv_on), .cfg_ok(cfg_ok)
    );

    // Accept requests only under a usable configuration.
    always_comb req_ready = cfg_ok;

    ilv_split #(.OFF_W(OFF_W), .TBL_N(TBL_N), .LG_W(LG_W)) u_split (
        .clk(clk), .rst_n(rst_n), .in_valid(req_valid && req_ready),
        .in_off(req_off), .line_lg2(cfg_line_lg2), .lines_lg2(lines_lg2),
        .ilv_on(ilv_on), .s1_valid(s1_valid), .s1_pass(s1_pass),
        .s1_raw(s1_raw), .s1_idx(s1_idx), .s1_skip(s1_skip), .s1_sub(s1_sub)
    );

    ilv_place #(.OFF_W(OFF_W), .ENT_W(ENT_W), .TBL_N(TBL_N),
                .WAYS_W(WAYS_W), .LG_W(LG_W)) u_place (
        .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_pass(s1_pass),
        .s1_raw(s1_raw), .s1_idx(s1_idx), .s1_skip(s1_skip), .s1_sub(s1_sub),
        .line_lg2(cfg_line_lg2), .lines_lg2(lines_lg2), .ways(cfg_ways),
        .base(cfg_base), .table_flat(cfg_table), .rsp_valid(rsp_valid),
        .rsp_off(rsp_off), .rsp_left(rsp_left), .rsp_err(rsp_err)
    );

    p_rsp_follows_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready, 2));
    p_accept_yields_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ##1 rsp_valid);
endmodule

// File: tb/sim_ilv_xlate.sv
// Bench: behavioural reference model with a queue of expected responses,
// compared at every falling clock edge.
module sim_ilv_xlate;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    cfg_line_lg2 = '0;
    logic [4:0]    cfg_num_lines = '0;
    logic [15:0]   cfg_ways = '0;
    logic [63:0]   cfg_base = '0;
    logic [511:0]  cfg_table;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [63:0]   req_off = '0;
    logic          rsp_valid;
    logic [63:0]   rsp_off;
    logic [16:0]   rsp_left;
    logic          rsp_err;

    logic [31:0] tbl [16];
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        logic [63:0] off;
        logic [16:0] left;
        logic        err;
        int          due;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 16; i++) cfg_table[i*32 +: 32] = tbl[i];
    end

    ilv_xlate u0 (
        .clk(clk), .rst_n(rst_n), .cfg_line_lg2(cfg_line_lg2),
        .cfg_num_lines(cfg_num_lines), .cfg_ways(cfg_ways),
        .cfg_base(cfg_base), .cfg_table(cfg_table), .req_valid(req_valid),
        .req_ready(req_ready), .req_off(req_off), .rsp_valid(rsp_valid),
        .rsp_off(rsp_off), .rsp_left(rsp_left), .rsp_err(rsp_err)
    );

    task automatic fail(string tag, string what, logic [127:0] act, logic [127:0] expv);
        errors++;
        $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    endtask

    // Reference: division and modulo on exact 128-bit arithmetic.
    function automatic exp_t model(logic [63:0] off, string tag);
        exp_t e;
        logic [127:0] ls, ln, sub, idx, skip, tot;
        e.tag = tag;
        if (cfg_num_lines == 0) begin
            e.off = off; e.left = '0; e.err = 1'b0;
            return e;
        end
        ls   = 128'(1) << cfg_line_lg2;
        ln   = 128'(off) / ls;
        sub  = 128'(off) % ls;
        idx  = ln % 128'(cfg_num_lines);
        skip = ln / 128'(cfg_num_lines);
        tot  = 128'(cfg_base) + 128'(tbl[idx[3:0]]) * ls
             + skip * (128'(cfg_num_lines) * 128'(cfg_ways) * ls) + sub;
        e.off  = tot[63:0];
        e.err  = (tot[127:64] != 0);
        e.left = 17'(ls - sub);
        return e;
    endfunction

    // Compare outputs against the expected queue (R6 timing and order).
    task automatic compare();
        if (rsp_valid) begin
            checks++;
            if (q.size() == 0 || q[0].due != cyc) begin
                fail("R6", "unexpected rsp_valid", 1, 0);
            end else begin
                exp_t e = q.pop_front();
                if (rsp_off !== e.off) fail(e.tag, "rsp_off", rsp_off, e.off);
                if (rsp_left !== e.left) fail(e.tag == "R2" ? "R2" : "R4", "rsp_left", rsp_left, e.left);
                if (rsp_err !== e.err) fail(e.tag == "R2" ? "R2" : "R5", "rsp_err", rsp_err, e.err);
            end
        end else if (q.size() != 0 && q[0].due == cyc) begin
            checks++;
            fail("R6", "missing rsp_valid", 0, 1);
            void'(q.pop_front());
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        compare();
        req_valid = 1'b0;
    endtask

    task automatic issue(logic [63:0] off, string tag);
        step();
        req_valid = 1'b1;
        req_off = off;
        if (req_ready) begin
            exp_t e = model(off, tag);
            e.due = cyc + 2;
            q.push_back(e);
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 4; i++) step();
    endtask

    task automatic check_ready(logic expv, string tag);
        checks++;
        if (req_ready !== expv) fail(tag, "req_ready", req_ready, expv);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) tbl[i] = 32'((i * 7 + 3) % 16);
        // R7: reset holds the response port idle.
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            checks++;
            if (rsp_valid !== 1'b0) fail("R7", "rsp_valid in reset", rsp_valid, 0);
        end
        rst_n = 1'b1;

        // R2: pass-through with zero ways accepted.
        cfg_num_lines = 0; cfg_ways = 0; cfg_base = 64'h1234;
        step(); check_ready(1'b1, "R2");
        issue(64'h0, "R2"); issue(64'hdead_beef_0000_0042, "R2");
        issue(64'hffff_ffff_ffff_ffff, "R2");
        drain();

        // R3/R4: 64-byte lines, 4 entries, 2 ways, back-to-back (R6).
        cfg_line_lg2 = 6; cfg_num_lines = 4; cfg_ways = 2; cfg_base = 64'h1000;
        step(); check_ready(1'b1, "R3");
        issue(0, "R3"); issue(63, "R3"); issue(64, "R3"); issue(130, "R3");
        issue(255, "R3"); issue(256, "R3"); issue(1000, "R3");
        issue(64'h0000_0123_4567_89ab, "R3");
        drain();

        // R8: smallest and largest line sizes; R3 with 16 entries.
        cfg_line_lg2 = 0; cfg_num_lines = 1; cfg_ways = 1; cfg_base = 0;
        step();
        issue(0, "R8"); issue(5, "R8"); issue(77, "R8");
        drain();
        cfg_line_lg2 = 15; cfg_num_lines = 16; cfg_ways = 3; cfg_base = 64'h40;
        step();
        issue(32767, "R8"); issue(32768, "R8"); issue(64'h0000_0001_0000_7fff, "R8");
        for (int i = 0; i < 6; i++) issue(64'($urandom) * 64'd40503, "R3");
        drain();

        // R5: overflow with the base near the top of the space.
        cfg_line_lg2 = 4; cfg_num_lines = 2; cfg_ways = 1;
        cfg_base = 64'hffff_ffff_ffff_fff0;
        tbl[0] = 0; tbl[1] = 1;
        step();
        issue(3, "R5"); issue(15, "R5"); issue(16, "R5"); issue(64'hffff_0000_0000_0000, "R5");
        drain();

        // R1: invalid configurations refuse and drop requests.
        cfg_num_lines = 4; cfg_ways = 0;
        step(); check_ready(1'b0, "R1");
        issue(64, "R1"); issue(128, "R1");
        drain();
        cfg_num_lines = 3; cfg_ways = 2;
        step(); check_ready(1'b0, "R1");
        issue(64, "R1");
        drain();
        checks++;
        if (q.size() != 0) fail("R1", "pending responses", q.size(), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule